// File: doc/BRIEF.md
# Flash Bus Command and Address Decoder

This block sits on the device side of a multiplexed 8-bit flash bus. It samples the shared I/O byte on every rising edge of the write strobe while the chip select is active. It classifies each sampled cycle as a command, an address or a data beat. Address beats are packed into a 12-bit column field and an 18-bit row field, and one row bit selects the plane. Setup and confirm commands are paired into operations. Each completed operation raises a one-clock start pulse on its own output, which a back end (array timer, page register, status logic) consumes.

All bus strobes are treated as slow inputs that are already synchronous to `clk`. Edges are found by comparing each strobe with its value on the previous clock. Program data leaves as a stream on `din_valid`/`din_data`. That stream has no ready signal, because a flash bus cannot be stalled: the consumer must take every beat in the clock it is offered. The array is represented only by the external `busy` input. While `busy` is high the decoder accepts only status queries and reset.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is taken when `we_n` rises while `ce_n` is low. The cycle is classified as follows:
  - `cle` high with `ale` low is a command.
  - `ale` high with `cle` low is an address.
  - Both low is a data beat.
  - Both high, or `ce_n` high, produces no cycle at all.
- R2: The five address beats fill the fields in this order:
  - Beat 1 gives `col_addr[7:0]`.
  - Bits 3:0 of beat 2 give `col_addr[11:8]`; its upper nibble is ignored.
  - Beat 3 gives `row_addr[7:0]`.
  - Beat 4 gives `row_addr[15:8]`.
  - Bits 1:0 of beat 5 give `row_addr[17:16]`.
  - `plane_sel` always equals `row_addr[6]`.
- R3: Address beats beyond the count the current command needs do not change `col_addr` or `row_addr`.
- R4: Reading works as follows:
  - Read setup 00h, five address beats and confirm 30h pulse `op_read`.
  - Confirm 35h in place of 30h pulses `op_copy_read`.
  - After reset the decoder is already in read setup, so address beats may start a read directly.
  - After a read confirm the decoder stays in read setup.
- R5: Programming works as follows:
  - 80h, five address beats, at least one data beat and 10h pulse `op_program`.
  - Each data beat after the full address is streamed out on `din_valid`/`din_data`.
  - 10h without a prior 80h, full address and data starts nothing.
- R6: Erase works as follows:
  - 60h, three address beats and D0h pulse `op_erase`.
  - The three beats fill `row_addr` only (beat 1 into bits 7:0, beat 2 into bits 15:8, beat 3 into bits 17:16).
  - `col_addr` is left unchanged.
- R7: Random column access works as follows:
  - 05h, two column beats and E0h pulse `op_rand_out`.
  - Inside a program sequence whose address is complete, 85h followed by two column beats reloads `col_addr` and keeps the row and the data already loaded.
- R8: While `busy` is high:
  - Only 70h, F1h and FFh are acted on.
  - Every other command, every address beat and every data beat is ignored.
  - A pending sequence therefore survives the busy period.
- R9: 70h or F1h pulses `op_status` in any state and leaves the pending sequence untouched.
- R10: FFh pulses `op_reset` in any state, busy or not, and returns the decoder to read setup.
- R11: Any other command that does not fit the current sequence (an unknown code, a wrong confirm, or a confirm before the address is complete) aborts the sequence. After an abort, address and data beats are ignored until a new setup command arrives.
- R12: The ID read works as follows:
  - 90h followed by an address beat of 00h pulses `op_read_id`; a non-zero beat aborts.
  - After that, each falling edge of `re_n` while `ce_n` is low returns the next byte of C8h, ACh, 90h, 15h, 54h on `id_data` with `id_valid`.
  - After the fifth byte the sequence wraps to the first.
- R13: Timing and priority rules:
  - A start pulse or data beat appears two clocks after the clock that first samples `we_n` high.
  - An ID byte appears two clocks after the clock that first samples `re_n` low.
  - At most one start pulse is high in any clock.
  - When a command cycle and an `re_n` fall are detected in the same clock, the command is handled and no ID byte is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command cycle qualifier |
| ale | input | 1 | Address cycle qualifier |
| we_n | input | 1 | Write strobe, sampled on its rising edge |
| re_n | input | 1 | Read strobe, ID byte on its falling edge |
| io_in | input | 8 | Shared command/address/data byte |
| busy | input | 1 | Array busy from the external timer |
| op_read | output | 1 | Page read start pulse |
| op_copy_read | output | 1 | Copy-back read start pulse |
| op_program | output | 1 | Page program start pulse |
| op_erase | output | 1 | Block erase start pulse |
| op_rand_out | output | 1 | Random column output start pulse |
| op_status | output | 1 | Status query pulse |
| op_reset | output | 1 | Reset pulse |
| op_read_id | output | 1 | ID read start pulse |
| col_addr | output | 12 | Packed column address |
| row_addr | output | 18 | Packed row address |
| plane_sel | output | 1 | Plane select taken from the row field |
| din_valid | output | 1 | Program data beat valid, no back-pressure |
| din_data | output | 8 | Program data byte |
| id_valid | output | 1 | ID byte valid |
| id_data | output | 8 | ID byte |

## Verification
Two functions can fall in the same clock: an ID byte request from an `re_n` fall and a command cycle from a `we_n` rise. The bench makes them coincide by releasing `we_n` (with a 70h status command on the bus) on the very clock where it pulls `re_n` low during ID output. The run passes when the status pulse appears, no ID byte is emitted, and the next `re_n` fall returns the byte that would otherwise have been skipped. The bench also places a status query inside a busy period that holds a pending read. It then checks that the query pulses while the read confirm issued during busy is dropped, and that a confirm issued after busy falls still completes the read.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned COL_W = 12;
  localparam int unsigned ROW_W = 18;
  localparam int unsigned ADDR_BEATS = 5;
  localparam int unsigned COL_BEATS = 2;
  localparam int unsigned BEAT_W = $clog2(ADDR_BEATS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDSET, ST_PROG, ST_ERASE, ST_RDOUT, ST_IDSET, ST_IDOUT
  } seq_st_e;

  localparam logic [BUS_W-1:0] K_READ     = 8'h00;
  localparam logic [BUS_W-1:0] K_READ_GO  = 8'h30;
  localparam logic [BUS_W-1:0] K_COPY_GO  = 8'h35;
  localparam logic [BUS_W-1:0] K_PROG     = 8'h80;
  localparam logic [BUS_W-1:0] K_PROG_GO  = 8'h10;
  localparam logic [BUS_W-1:0] K_ERASE    = 8'h60;
  localparam logic [BUS_W-1:0] K_ERASE_GO = 8'hD0;
  localparam logic [BUS_W-1:0] K_ROUT     = 8'h05;
  localparam logic [BUS_W-1:0] K_ROUT_GO  = 8'hE0;
  localparam logic [BUS_W-1:0] K_RIN      = 8'h85;
  localparam logic [BUS_W-1:0] K_ID       = 8'h90;
  localparam logic [BUS_W-1:0] K_STAT     = 8'h70;
  localparam logic [BUS_W-1:0] K_STAT2    = 8'hF1;
  localparam logic [BUS_W-1:0] K_RST      = 8'hFF;

  typedef struct packed {
    logic rd;
    logic cprd;
    logic prog;
    logic erase;
    logic rout;
    logic stat;
    logic rst;
    logic id;
  } op_t;
endpackage

// File: rtl/nfe_strobe.sv
module nfe_strobe
  import nfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic [BUS_W-1:0] io_in,
  output logic             ev_cmd,
  output logic             ev_addr,
  output logic             ev_data,
  output logic             ev_re,
  output logic [BUS_W-1:0] ev_byte
);
  logic we_q, re_q, wr_hit;

  assign wr_hit = we_n & ~we_q & ~ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      re_q    <= 1'b1;
      ev_cmd  <= 1'b0;
      ev_addr <= 1'b0;
      ev_data <= 1'b0;
      ev_re   <= 1'b0;
      ev_byte <= '0;
    end else begin
      we_q    <= we_n;
      re_q    <= re_n;
      ev_cmd  <= wr_hit & cle & ~ale;
      ev_addr <= wr_hit & ale & ~cle;
      ev_data <= wr_hit & ~cle & ~ale;
      ev_re   <= ~re_n & re_q & ~ce_n;
      if (wr_hit) ev_byte <= io_in;
    end
  end

  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd, ev_addr, ev_data}));
endmodule

// File: rtl/nfe_addr_pack.sv
module nfe_addr_pack
  import nfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_col,
  input  logic             clr_row,
  input  logic             take,
  input  logic [BUS_W-1:0] beat,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             full
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(ADDR_BEATS);
  localparam logic [BEAT_W-1:0] COL_END = BEAT_W'(COL_BEATS);

  logic [BEAT_W-1:0] idx, lim;
  logic unused_hi;

  assign unused_hi = ^beat[7:4];
  assign full = (idx == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      lim <= LAST;
      col <= '0;
      row <= '0;
    end else if (clr_all) begin
      idx <= '0;
      lim <= LAST;
    end else if (clr_col) begin
      idx <= '0;
      lim <= COL_END;
    end else if (clr_row) begin
      idx <= COL_END;
      lim <= LAST;
    end else if (take && idx < lim) begin
      idx <= idx + 1'b1;
      case (idx)
        3'd0:    col[7:0]   <= beat;
        3'd1:    col[11:8]  <= beat[3:0];
        3'd2:    row[7:0]   <= beat;
        3'd3:    row[15:8]  <= beat;
        default: row[17:16] <= beat[1:0];
      endcase
    end
  end

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= lim);
  assert_extra_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full && !clr_all && !clr_col && !clr_row) |=> ($stable(col) && $stable(row)));
endmodule

// File: rtl/nfe_id_gen.sv
module nfe_id_gen
  import nfe_pkg::*;
#(
  parameter int unsigned ID_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic             id_valid,
  output logic [BUS_W-1:0] id_data
);
  localparam int unsigned IDX_W = $clog2(ID_LEN);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ID_LEN - 1);

  logic [IDX_W-1:0] idx;

  function automatic logic [BUS_W-1:0] id_byte(input logic [IDX_W-1:0] i);
    case (i)
      0:       return 8'hC8;
      1:       return 8'hAC;
      2:       return 8'h90;
      3:       return 8'h15;
      default: return 8'h54;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      id_valid <= 1'b0;
      id_data  <= '0;
    end else if (start) begin
      idx      <= '0;
      id_valid <= 1'b0;
    end else if (step) begin
      id_data  <= id_byte(idx);
      id_valid <= 1'b1;
      idx      <= (idx == TOP) ? '0 : idx + 1'b1;
    end else begin
      id_valid <= 1'b0;
    end
  end

  assert_id_idx_R12: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= TOP);
endmodule

// File: rtl/nfe_seq.sv
module nfe_seq
  import nfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_cmd,
  input  logic             ev_addr,
  input  logic             ev_data,
  input  logic             ev_re,
  input  logic [BUS_W-1:0] ev_byte,
  input  logic             busy,
  input  logic             addr_full,
  output op_t              ops,
  output logic             pk_clr,
  output logic             pk_col,
  output logic             pk_row,
  output logic             pk_take,
  output logic             id_start,
  output logic             id_step,
  output logic             din_valid,
  output logic [BUS_W-1:0] din_data
);
  seq_st_e st, st_n;
  op_t     op_n;
  logic    loaded, loaded_n, dv_n;

  always_comb begin
    st_n     = st;
    op_n     = '0;
    loaded_n = loaded;
    dv_n     = 1'b0;
    pk_clr   = 1'b0;
    pk_col   = 1'b0;
    pk_row   = 1'b0;
    pk_take  = 1'b0;
    id_start = 1'b0;
    id_step  = 1'b0;
    if (ev_cmd) begin
      if (ev_byte == K_STAT || ev_byte == K_STAT2) begin
        op_n.stat = 1'b1;
      end else if (ev_byte == K_RST) begin
        op_n.rst = 1'b1;
        st_n     = ST_RDSET;
        pk_clr   = 1'b1;
      end else if (!busy) begin
        st_n = ST_IDLE;
        case (ev_byte)
          K_READ:  begin st_n = ST_RDSET; pk_clr = 1'b1; end
          K_PROG:  begin st_n = ST_PROG; pk_clr = 1'b1; loaded_n = 1'b0; end
          K_ERASE: begin st_n = ST_ERASE; pk_row = 1'b1; end
          K_ROUT:  begin st_n = ST_RDOUT; pk_col = 1'b1; end
          K_ID:    st_n = ST_IDSET;
          K_RIN:
            if (st == ST_PROG && addr_full) begin
              st_n   = ST_PROG;
              pk_col = 1'b1;
            end
          K_READ_GO, K_COPY_GO:
            if (st == ST_RDSET && addr_full) begin
              st_n   = ST_RDSET;
              pk_clr = 1'b1;
              if (ev_byte == K_READ_GO) op_n.rd = 1'b1;
              else op_n.cprd = 1'b1;
            end
          K_PROG_GO:  op_n.prog  = (st == ST_PROG) && addr_full && loaded;
          K_ERASE_GO: op_n.erase = (st == ST_ERASE) && addr_full;
          K_ROUT_GO:  op_n.rout  = (st == ST_RDOUT) && addr_full;
          default: ;
        endcase
      end
    end else if (ev_addr && !busy) begin
      case (st)
        ST_RDSET, ST_PROG, ST_ERASE, ST_RDOUT: pk_take = 1'b1;
        ST_IDSET:
          if (ev_byte == '0) begin
            op_n.id  = 1'b1;
            id_start = 1'b1;
            st_n     = ST_IDOUT;
          end else begin
            st_n = ST_IDLE;
          end
        default: ;
      endcase
    end else if (ev_data && !busy && st == ST_PROG && addr_full) begin
      dv_n     = 1'b1;
      loaded_n = 1'b1;
    end
    if (ev_re && !ev_cmd && st == ST_IDOUT) id_step = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_RDSET;
      ops       <= '0;
      loaded    <= 1'b0;
      din_valid <= 1'b0;
      din_data  <= '0;
    end else begin
      st        <= st_n;
      ops       <= op_n;
      loaded    <= loaded_n;
      din_valid <= dv_n;
      if (dv_n) din_data <= ev_byte;
    end
  end

  assert_one_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ops));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && busy && ev_byte != K_STAT && ev_byte != K_STAT2 && ev_byte != K_RST)
      |=> (st == $past(st)));
  assert_reset_rdset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && ev_byte == K_RST) |=> (st == ST_RDSET && ops.rst));
  assert_din_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |-> ($past(st) == ST_PROG && !$past(busy)));
  assert_status_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && (ev_byte == K_STAT || ev_byte == K_STAT2)) |=> (st == $past(st)));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nfe_pkg::*;
#(
  parameter int unsigned PLANE_BIT = 6,
  parameter int unsigned ID_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic [7:0]       io_in,
  input  logic             busy,
  output logic             op_read,
  output logic             op_copy_read,
  output logic             op_program,
  output logic             op_erase,
  output logic             op_rand_out,
  output logic             op_status,
  output logic             op_reset,
  output logic             op_read_id,
  output logic [11:0]      col_addr,
  output logic [17:0]      row_addr,
  output logic             plane_sel,
  output logic             din_valid,
  output logic [7:0]       din_data,
  output logic             id_valid,
  output logic [7:0]       id_data
);
  logic             ev_cmd, ev_addr, ev_data, ev_re;
  logic [BUS_W-1:0] ev_byte;
  logic             pk_clr, pk_col, pk_row, pk_take, full;
  logic             id_start, id_step;
  op_t              ops;

  nfe_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in),
    .ev_cmd(ev_cmd), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_re(ev_re), .ev_byte(ev_byte)
  );

  nfe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_re(ev_re), .ev_byte(ev_byte), .busy(busy),
    .addr_full(full), .ops(ops), .pk_clr(pk_clr), .pk_col(pk_col),
    .pk_row(pk_row), .pk_take(pk_take), .id_start(id_start),
    .id_step(id_step), .din_valid(din_valid), .din_data(din_data)
  );

  nfe_addr_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr_all(pk_clr), .clr_col(pk_col),
    .clr_row(pk_row), .take(pk_take), .beat(ev_byte),
    .col(col_addr), .row(row_addr), .full(full)
  );

  nfe_id_gen #(.ID_LEN(ID_LEN)) u_id (
    .clk(clk), .rst_n(rst_n), .start(id_start), .step(id_step),
    .id_valid(id_valid), .id_data(id_data)
  );

  assign op_read      = ops.rd;
  assign op_copy_read = ops.cprd;
  assign op_program   = ops.prog;
  assign op_erase     = ops.erase;
  assign op_rand_out  = ops.rout;
  assign op_status    = ops.stat;
  assign op_reset     = ops.rst;
  assign op_read_id   = ops.id;
  assign plane_sel    = row_addr[PLANE_BIT];
endmodule

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, ce_n = 0, cle = 0, ale = 0, we_n = 1, re_n = 1, busy = 0;
  logic [7:0] io_in = 0;
  logic op_read, op_copy_read, op_program, op_erase, op_rand_out, op_status, op_reset, op_read_id;
  logic [11:0] col_addr;
  logic [17:0] row_addr;
  logic plane_sel, din_valid, id_valid;
  logic [7:0] din_data, id_data;

  always #(CLK_P/2) clk = ~clk;

  nand_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .busy(busy), .op_read(op_read),
    .op_copy_read(op_copy_read), .op_program(op_program), .op_erase(op_erase),
    .op_rand_out(op_rand_out), .op_status(op_status), .op_reset(op_reset),
    .op_read_id(op_read_id), .col_addr(col_addr), .row_addr(row_addr),
    .plane_sel(plane_sel), .din_valid(din_valid), .din_data(din_data),
    .id_valid(id_valid), .id_data(id_data)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mst, a_idx, a_end, m_col, m_row;
  bit loaded, m_weq, m_req, p_cmd, p_addr, p_data, p_re;
  byte unsigned p_b;
  byte unsigned idq[$];
  bit [7:0] e_op; // rd,cprd,prog,erase,rout,stat,rst,id
  bit e_dv, e_iv;
  byte unsigned e_din, e_id;

  task automatic fill_id();
    idq = {8'hC8, 8'hAC, 8'h90, 8'h15, 8'h54};
  endtask

  task automatic put_beat(input byte unsigned b);
    case (a_idx)
      0: m_col = (m_col / 256) * 256 + b;
      1: m_col = (m_col % 256) + (b % 16) * 256;
      2: m_row = (m_row / 256) * 256 + b;
      3: m_row = (m_row / 65536) * 65536 + b * 256 + (m_row % 256);
      default: m_row = (m_row % 65536) + (b % 4) * 65536;
    endcase
    a_idx++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 1; a_idx = 0; a_end = 5; m_col = 0; m_row = 0; loaded = 0;
      m_weq = 1; m_req = 1; p_cmd = 0; p_addr = 0; p_data = 0; p_re = 0; p_b = 0;
      e_op = 0; e_dv = 0; e_iv = 0; e_din = 0; e_id = 0;
      fill_id();
    end else begin
      int st0;
      st0 = mst;
      e_op = 0; e_dv = 0; e_iv = 0;
      if (p_cmd) begin
        if (p_b == 8'h70 || p_b == 8'hF1) e_op[2] = 1;
        else if (p_b == 8'hFF) begin e_op[1] = 1; mst = 1; a_idx = 0; a_end = 5; end
        else if (!busy) begin
          mst = 0;
          case (p_b)
            8'h00: begin mst = 1; a_idx = 0; a_end = 5; end
            8'h80: begin mst = 2; a_idx = 0; a_end = 5; loaded = 0; end
            8'h60: begin mst = 3; a_idx = 2; a_end = 5; end
            8'h05: begin mst = 4; a_idx = 0; a_end = 2; end
            8'h90: mst = 5;
            8'h85: if (st0 == 2 && a_idx == a_end) begin mst = 2; a_idx = 0; a_end = 2; end
            8'h30, 8'h35: if (st0 == 1 && a_idx == a_end) begin
              mst = 1; a_idx = 0; a_end = 5;
              if (p_b == 8'h30) e_op[7] = 1; else e_op[6] = 1;
            end
            8'h10: e_op[5] = (st0 == 2 && a_idx == a_end && loaded);
            8'hD0: e_op[4] = (st0 == 3 && a_idx == a_end);
            8'hE0: e_op[3] = (st0 == 4 && a_idx == a_end);
            default: ;
          endcase
        end
      end else if (p_addr && !busy) begin
        if (mst >= 1 && mst <= 4) begin
          if (a_idx < a_end) put_beat(p_b);
        end else if (mst == 5) begin
          if (p_b == 0) begin e_op[0] = 1; fill_id(); mst = 6; end
          else mst = 0;
        end
      end else if (p_data && !busy && mst == 2 && a_idx == a_end) begin
        e_dv = 1; e_din = p_b; loaded = 1;
      end
      if (p_re && !p_cmd && st0 == 6) begin
        byte unsigned b;
        b = idq.pop_front();
        idq.push_back(b);
        e_iv = 1; e_id = b;
      end
      p_cmd  = we_n && !m_weq && !ce_n && cle && !ale;
      p_addr = we_n && !m_weq && !ce_n && ale && !cle;
      p_data = we_n && !m_weq && !ce_n && !ale && !cle;
      if (we_n && !m_weq && !ce_n) p_b = io_in;
      p_re = !re_n && m_req && !ce_n;
      m_weq = we_n;
      m_req = re_n;
    end
  end

  // per-clock comparison and pulse counters
  int c_rd, c_cp, c_pg, c_er, c_ro, c_st, c_rs, c_id, c_dv, c_iv;
  byte unsigned id_log[$];
  byte unsigned din_log[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(op_read == e_op[7], "R4 op_read", op_read, e_op[7]);
      chk(op_copy_read == e_op[6], "R4 op_copy_read", op_copy_read, e_op[6]);
      chk(op_program == e_op[5], "R5 op_program", op_program, e_op[5]);
      chk(op_erase == e_op[4], "R6 op_erase", op_erase, e_op[4]);
      chk(op_rand_out == e_op[3], "R7 op_rand_out", op_rand_out, e_op[3]);
      chk(op_status == e_op[2], "R9 op_status", op_status, e_op[2]);
      chk(op_reset == e_op[1], "R10 op_reset", op_reset, e_op[1]);
      chk(op_read_id == e_op[0], "R12 op_read_id", op_read_id, e_op[0]);
      chk(col_addr == m_col[11:0], "R2 col_addr", col_addr, m_col);
      chk(row_addr == m_row[17:0], "R2 row_addr", row_addr, m_row);
      chk(plane_sel == m_row[6], "R2 plane_sel", plane_sel, m_row[6]);
      chk(din_valid == e_dv, "R5 din_valid", din_valid, e_dv);
      if (e_dv) chk(din_data == e_din, "R5 din_data", din_data, e_din);
      chk(id_valid == e_iv, "R12 id_valid", id_valid, e_iv);
      if (e_iv) chk(id_data == e_id, "R12 id_data", id_data, e_id);
      c_rd += op_read; c_cp += op_copy_read; c_pg += op_program; c_er += op_erase;
      c_ro += op_rand_out; c_st += op_status; c_rs += op_reset; c_id += op_read_id;
      if (din_valid) begin c_dv++; din_log.push_back(din_data); end
      if (id_valid) begin c_iv++; id_log.push_back(id_data); end
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input int kind, input byte unsigned b);
    @(negedge clk);
    cle = (kind == 0); ale = (kind == 1); io_in = b; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    repeat (3) @(negedge clk);
    cle = 0; ale = 0;
  endtask

  task automatic cmd(input byte unsigned b); bus(0, b); endtask
  task automatic adr(input byte unsigned b); bus(1, b); endtask
  task automatic dat(input byte unsigned b); bus(2, b); endtask

  task automatic re_pulse();
    @(negedge clk); re_n = 0;
    repeat (2) @(negedge clk); re_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog R13 actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int c0, s0, i0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(col_addr == 0 && row_addr == 0 && !op_read && !din_valid && !id_valid,
        "R10 reset state", {col_addr, row_addr}, 0);

    // R4/R2: read straight from reset, upper nibble of beat 2 dropped
    adr(8'h34); adr(8'hA7); adr(8'h5C); adr(8'h3E); adr(8'h7F); cmd(8'h30);
    chk(c_rd == 1, "R4 read from reset", c_rd, 1);
    chk(col_addr == 12'h734, "R2 column packing", col_addr, 12'h734);
    chk(row_addr == 18'h33E5C, "R2 row packing", row_addr, 18'h33E5C);
    chk(plane_sel == 1'b1, "R2 plane bit", plane_sel, 1);

    // R3: sixth beat ignored, copy-back confirm
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h01); adr(8'hFF);
    cmd(8'h35);
    chk(c_cp == 1, "R4 copy read", c_cp, 1);
    chk(row_addr == 18'h10403, "R3 extra beat ignored", row_addr, 18'h10403);

    // R5/R7: program with random input
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h40); adr(8'h00); adr(8'h00);
    dat(8'hAA); dat(8'h55); dat(8'h0F);
    cmd(8'h85); adr(8'h10); adr(8'h02); dat(8'h77); cmd(8'h10);
    chk(c_pg == 1, "R5 program pulse", c_pg, 1);
    chk(c_dv == 4, "R5 data beats", c_dv, 4);
    chk(din_log.size() == 4 && din_log[3] == 8'h77, "R5 last data", din_log[din_log.size()-1], 8'h77);
    chk(col_addr == 12'h210, "R7 random input column", col_addr, 12'h210);
    chk(row_addr == 18'h00040, "R7 row kept", row_addr, 18'h40);

    // R5/R11: lone confirm and stray data do nothing
    cmd(8'h10); dat(8'h99);
    chk(c_pg == 1, "R5 lone confirm", c_pg, 1);
    chk(c_dv == 4, "R11 data after abort", c_dv, 4);

    // R6: erase keeps column
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h00); cmd(8'hD0);
    chk(c_er == 1, "R6 erase pulse", c_er, 1);
    chk(row_addr == 18'h00201 && col_addr == 12'h210, "R6 row only", row_addr, 18'h201);

    // R7: random output
    cmd(8'h05); adr(8'h22); adr(8'h01); cmd(8'hE0);
    chk(c_ro == 1 && col_addr == 12'h122, "R7 random output", col_addr, 12'h122);

    // R8/R9: busy keeps a pending read
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h05); adr(8'h00); adr(8'h00);
    busy = 1;
    s0 = c_st;
    cmd(8'h30); cmd(8'h80); adr(8'h66); cmd(8'h70); cmd(8'hF1);
    chk(c_rd == 1, "R8 confirm ignored while busy", c_rd, 1);
    chk(col_addr == 0 && row_addr == 18'h5, "R8 address ignored while busy", row_addr, 5);
    chk(c_st == s0 + 2, "R9 status while busy", c_st, s0 + 2);
    busy = 0;
    cmd(8'h30);
    chk(c_rd == 2, "R8 sequence survives busy", c_rd, 2);

    // R11: wrong confirm aborts
    cmd(8'h80); adr(8'h01); adr(8'h00); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30);
    dat(8'h12); cmd(8'h10);
    chk(c_pg == 1 && c_dv == 4, "R11 abort", c_pg, 1);

    // R10: reset mid erase, then direct read
    cmd(8'h60); adr(8'h07); cmd(8'hFF);
    chk(c_rs == 1, "R10 reset pulse", c_rs, 1);
    adr(8'h00); adr(8'h00); adr(8'h09); adr(8'h00); adr(8'h00); cmd(8'h30);
    chk(c_rd == 3 && c_er == 1, "R10 read setup after reset", c_rd, 3);

    // R12: ID bytes and wrap
    cmd(8'h90); adr(8'h00);
    chk(c_id == 1, "R12 id start", c_id, 1);
    for (int k = 0; k < 7; k++) re_pulse();
    chk(id_log.size() == 7, "R12 id count", id_log.size(), 7);
    chk(id_log[0] == 8'hC8 && id_log[1] == 8'hAC && id_log[4] == 8'h54, "R12 id order", id_log[4], 8'h54);
    chk(id_log[5] == 8'hC8 && id_log[6] == 8'hAC, "R12 id wrap", id_log[5], 8'hC8);

    // R13: command and RE fall detected in the same clock
    i0 = c_iv; s0 = c_st;
    @(negedge clk); cle = 1; io_in = 8'h70; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1; re_n = 0;
    @(negedge clk); #1;
    chk(op_status == 0, "R13 latency before", op_status, 0);
    @(negedge clk); #1;
    chk(op_status == 1, "R13 latency status", op_status, 1);
    re_n = 1; cle = 0;
    repeat (3) @(negedge clk);
    chk(c_iv == i0 && c_st == s0 + 1, "R13 command wins", c_iv, i0);
    re_pulse();
    chk(id_log[id_log.size()-1] == 8'h90, "R12 next id byte", id_log[id_log.size()-1], 8'h90);

    // R1: chip select high and both qualifiers high
    s0 = c_st;
    ce_n = 1; cmd(8'h70); ce_n = 0;
    @(negedge clk); cle = 1; ale = 1; io_in = 8'h70; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (3) @(negedge clk); cle = 0; ale = 0;
    chk(c_st == s0, "R1 no cycle when deselected or both high", c_st, s0);
    c0 = c_dv;
    ce_n = 1; dat(8'h44); ce_n = 0;
    chk(c_dv == c0, "R1 data while deselected", c_dv, c0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule